// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block takes one asynchronous serial line and turns each frame on it into a byte for a downstream consumer. The line rests high. A frame starts with a single low start bit. Then come five to eight data bits, least significant bit first, and an optional parity bit. A single high stop bit closes the frame. The data length, the use of parity and the parity sense are static configuration pins. The bit period comes from a small code that picks one of seven standard line rates. The divider for each rate is computed from the system clock frequency parameter, which is 60 MHz by default.

The incoming line first passes through a two-stage synchronizer. A falling edge is taken as a start bit only if the line is still low half a bit period later. From that point every bit is sampled once, at its middle. Each finished byte leaves on a valid/ready output stream together with two per-byte flags, one for parity error and one for framing error. The output stage holds one byte. While `m_valid` is high and `m_ready` is low, the byte and its flags stay unchanged. The receiver cannot pause the line, so a byte that finishes before the consumer has accepted the previous one replaces it. A consumer must therefore accept each byte within one frame time.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, `m_valid` is 0, and a line held high produces no output byte.
- R2: A low pulse on `rx_i` that ends before the middle of the would-be start bit is ignored and produces no byte.
- R3: `cfg_bits` picks the data length as 5 + `cfg_bits` (0 gives 5 bits, 3 gives 8 bits). Bits are received least significant first, and any upper bits of `m_data` beyond that length are 0.
- R4: When `cfg_par_en` is 1, a parity bit follows the data. `cfg_par_odd` = 0 expects even parity and 1 expects odd parity over the data and parity bits together. `m_perr` is 1 with the byte exactly when the received parity bit does not match. When `cfg_par_en` is 0, no parity bit is expected and `m_perr` is 0.
- R5: A stop bit sampled as 0 delivers the byte with `m_ferr` = 1. After that, no new start bit is recognised until the line has gone high again.
- R6: `cfg_rate` codes 0 to 6 select 2400, 4800, 9600, 19200, 38400, 57600 and 115200 bit/s, and code 7 also selects 115200. The bit period is CLK_HZ / rate clock cycles, rounded to the nearest integer.
- R7: While `m_valid` is 1 and `m_ready` is 0, `m_valid`, `m_data`, `m_perr` and `m_ferr` hold their values until a new byte completes.
- R8: A byte that completes while an earlier byte is still unaccepted replaces it. If a byte completes in the same cycle that the previous one is accepted, `m_valid` stays 1 and now carries the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, asynchronous to clk |
| cfg_bits | input | 2 | Data length minus 5 |
| cfg_par_en | input | 1 | 1: a parity bit follows the data |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_rate | input | 3 | Line rate code |
| m_valid | output | 1 | Output byte available |
| m_ready | input | 1 | Consumer accepts the byte this cycle |
| m_data | output | 8 | Received byte, zero-extended |
| m_perr | output | 1 | Parity error flag for this byte |
| m_ferr | output | 1 | Framing error flag for this byte |

## Verification
Two events can land in the same clock cycle: the consumer accepting the held byte, and the frame engine completing the next byte. The bench holds `m_ready` low through one frame. It then sends a second frame and raises `m_ready` in the cycle it computes for that frame's stop-bit completion. Whichever way the edge falls, the run is judged correct only if both bytes are taken in order, neither is lost and neither is taken twice.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned MIN_BITS     = 5;
  localparam int unsigned SLOWEST_RATE = 2400;
  localparam int unsigned RATE_SLOTS   = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rx_state_e;

  // Line rate in bit/s for a rate code; code 7 reuses the fastest rate.
  function automatic int unsigned rate_of(input logic [2:0] code);
    case (code)
      3'd5:       return 57600;
      3'd6, 3'd7: return 115200;
      default:    return SLOWEST_RATE << code;
    endcase
  endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE_V = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{IDLE_V}};
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_rate.sv
module serial_rx_rate
  import serial_rx_pkg::*;
#(
  parameter int unsigned CLK_HZ = 60_000_000,
  parameter int unsigned CW     = 16
) (
  input  logic [2:0]    code_i,
  output logic [CW-1:0] period_o,
  output logic [CW-1:0] half_o
);
  logic [CW-1:0] table_q [RATE_SLOTS];

  for (genvar i = 0; i < RATE_SLOTS; i++) begin : g_rate
    localparam int unsigned RATE = rate_of(3'(i));
    localparam int unsigned DIV  = (CLK_HZ + RATE / 2) / RATE;
    assign table_q[i] = CW'(DIV);
  end

  assign period_o = table_q[code_i];
  assign half_o   = period_o >> 1;
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic [1:0]        len_sel_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic [CW-1:0]     period_i,
  input  logic [CW-1:0]     half_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o
);
  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [2:0]        idx;
  logic [BYTE_W-1:0] shreg;
  logic              par_bit;
  logic [2:0]        last_idx;
  logic [1:0]        align_sh;
  logic [BYTE_W-1:0] aligned;
  logic              bit_tick;

  assign last_idx = 3'(MIN_BITS - 1) + 3'(len_sel_i);
  assign align_sh = 2'd3 - len_sel_i;
  assign aligned  = shreg >> align_sh;
  assign bit_tick = (cnt == period_i - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      done_o  <= 1'b0;
      data_o  <= '0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (!line_i) state <= ST_START;
        end
        ST_START: begin
          if (cnt == half_i - 1'b1) begin
            cnt <= '0;
            idx <= '0;
            state <= line_i ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (bit_tick) begin
            cnt   <= '0;
            shreg <= {line_i, shreg[BYTE_W-1:1]};
            if (idx == last_idx) state <= par_en_i ? ST_PAR : ST_STOP;
            else                 idx   <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (bit_tick) begin
            cnt     <= '0;
            par_bit <= line_i;
            state   <= ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (bit_tick) begin
            cnt    <= '0;
            done_o <= 1'b1;
            data_o <= aligned;
            perr_o <= par_en_i & (^aligned ^ par_bit ^ par_odd_i);
            ferr_o <= ~line_i;
            state  <= line_i ? ST_IDLE : ST_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          cnt <= '0;
          if (line_i) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_out.sv
module serial_rx_out
  import serial_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              perr_i,
  input  logic              ferr_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      perr_o  <= perr_i;
      ferr_o  <= ferr_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import serial_rx_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 60_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  input  logic [1:0] cfg_bits,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic [2:0] cfg_rate,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data,
  output logic       m_perr,
  output logic       m_ferr
);
  localparam int unsigned CW = $clog2(CLK_HZ / SLOWEST_RATE + 2);

  logic              line_s;
  logic [CW-1:0]     period;
  logic [CW-1:0]     half;
  logic              frm_done;
  logic [BYTE_W-1:0] frm_data;
  logic              frm_perr;
  logic              frm_ferr;

  serial_rx_sync #(.STAGES(SYNC_STAGES), .IDLE_V(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(line_s)
  );

  serial_rx_rate #(.CLK_HZ(CLK_HZ), .CW(CW)) u_rate (
    .code_i(cfg_rate), .period_o(period), .half_o(half)
  );

  serial_rx_frame #(.CW(CW)) u_frame (
    .clk(clk), .rst_n(rst_n), .line_i(line_s),
    .len_sel_i(cfg_bits), .par_en_i(cfg_par_en), .par_odd_i(cfg_par_odd),
    .period_i(period), .half_i(half),
    .done_o(frm_done), .data_o(frm_data), .perr_o(frm_perr), .ferr_o(frm_ferr)
  );

  serial_rx_out u_out (
    .clk(clk), .rst_n(rst_n), .load_i(frm_done), .data_i(frm_data),
    .perr_i(frm_perr), .ferr_i(frm_ferr), .ready_i(m_ready),
    .valid_o(m_valid), .data_o(m_data), .perr_o(m_perr), .ferr_o(m_ferr)
  );
endmodule

// File: rtl/serial_frame_rx_chk.sv
module serial_frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_bits,
  input logic       cfg_par_en,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       m_perr,
  input logic       m_ferr,
  input logic       frm_done
);
  // R7: an unaccepted byte stays presented
  p_hold_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid);

  // R7: payload and flags frozen while stalled with nothing new arriving
  p_stable_payload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !frm_done) |=> ($stable(m_data) && $stable(m_perr) && $stable(m_ferr)));

  // R8: a completed frame is always presented next cycle, regardless of ready
  p_done_presents_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |=> m_valid);

  // R4: parity error only possible with parity enabled
  p_perr_needs_par_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_perr) |-> cfg_par_en);

  // R3: bits above the configured length are zero
  p_zero_extend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> ((m_data >> (5 + cfg_bits)) == 8'd0));

  // R1: nothing presented without a completed frame
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_valid && !frm_done) |=> !m_valid);
endmodule

bind serial_frame_rx serial_frame_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_bits(cfg_bits), .cfg_par_en(cfg_par_en),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .m_perr(m_perr), .m_ferr(m_ferr), .frm_done(frm_done)
);

// File: tb/serial_frame_rx_test.sv
module serial_frame_rx_test;
  localparam int unsigned CLK_HZ_TB = 1_152_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_i = 1'b1;
  logic [1:0] cfg_bits = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic [2:0] cfg_rate = 3'd6;
  logic       m_valid;
  logic       m_ready = 1'b1;
  logic [7:0] m_data;
  logic       m_perr;
  logic       m_ferr;

  int n_checks = 0;
  int n_err = 0;
  int cyc = 0;
  int cap_n = 0;
  logic [9:0] cap_q [256];

  serial_frame_rx #(.CLK_HZ(CLK_HZ_TB)) uut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .cfg_bits(cfg_bits),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_rate(cfg_rate),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_perr(m_perr), .m_ferr(m_ferr)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      cap_q[cap_n % 256] = {m_ferr, m_perr, m_data};
      cap_n++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_err++;
      $display("FAIL R1 watchdog actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  function automatic int bit_cycles(input int code);
    int rate;
    if (code == 5)      rate = 57600;
    else if (code >= 6) rate = 115200;
    else                rate = 2400 << code;
    return (CLK_HZ_TB + rate / 2) / rate;
  endfunction

  function automatic logic [7:0] expect_data(input logic [7:0] d, input int nb);
    return d & 8'((1 << nb) - 1);
  endfunction

  task automatic check_eq(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    @(negedge clk);
    rx_i = v;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                            input bit podd, input bit bad, input bit stop_v, input int bc);
    logic p;
    p = ^expect_data(d, nb);
    if (podd) p = ~p;
    if (bad)  p = ~p;
    drive(1'b0, bc);
    for (int i = 0; i < nb; i++) drive(d[i], bc);
    if (pen) drive(p, bc);
    drive(stop_v, bc);
    rx_i = 1'b1;
  endtask

  task automatic set_cfg(input int bits, input bit pen, input bit podd, input int code);
    @(negedge clk);
    cfg_bits = 2'(bits);
    cfg_par_en = pen;
    cfg_par_odd = podd;
    cfg_rate = 3'(code);
  endtask

  // One frame with ready high, checked for count, data and flags.
  task automatic one_frame(input string tag, input logic [7:0] d, input int bits,
                           input bit pen, input bit podd, input bit bad, input int code);
    int base;
    logic [9:0] got;
    set_cfg(bits, pen, podd, code);
    base = cap_n;
    send_frame(d, bits + 5, pen, podd, bad, 1'b1, bit_cycles(code));
    repeat (4) @(negedge clk);
    check_eq({tag, " count"}, cap_n - base, 1);
    got = cap_q[base % 256];
    check_eq({tag, " data"}, got[7:0], expect_data(d, bits + 5));
    check_eq({tag, " perr"}, got[8], pen & bad);
    check_eq({tag, " ferr"}, got[9], 0);
  endtask

  initial begin
    int base;
    int bc;
    void'($urandom(32'h0005eed1));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 reset valid", m_valid, 0);
    repeat (60) @(negedge clk);
    check_eq("R1 idle line no byte", cap_n, 0);

    // R3 lengths and zero extension
    one_frame("R3 8bit", 8'hA5, 3, 0, 0, 0, 6);
    one_frame("R3 5bit zext", 8'hFF, 0, 0, 0, 0, 6);
    one_frame("R3 6bit", 8'h2D, 1, 0, 0, 0, 5);
    // R4 parity
    one_frame("R4 even ok", 8'h6B, 2, 1, 0, 0, 6);
    one_frame("R4 odd bad", 8'h3C, 3, 1, 1, 1, 6);
    one_frame("R4 even bad", 8'h01, 0, 1, 0, 1, 4);
    one_frame("R4 odd ok", 8'h80, 3, 1, 1, 0, 4);
    // R6 slowest and a middle rate
    one_frame("R6 rate0", 8'h5A, 3, 0, 0, 0, 0);
    one_frame("R6 rate3", 8'hC3, 3, 1, 0, 0, 3);
    one_frame("R6 code7", 8'h96, 3, 0, 0, 0, 7);

    // R2 short glitch rejected
    set_cfg(3, 0, 0, 6);
    base = cap_n;
    drive(1'b0, 3);
    rx_i = 1'b1;
    repeat (40) @(negedge clk);
    check_eq("R2 glitch no byte", cap_n - base, 0);
    one_frame("R2 frame after glitch", 8'h4E, 3, 0, 0, 0, 6);

    // R5 framing error, then line held low must not start a frame
    bc = bit_cycles(6);
    base = cap_n;
    send_frame(8'h55, 8, 0, 0, 0, 1'b0, bc);
    rx_i = 1'b0;
    repeat (3 * bc) @(negedge clk);
    rx_i = 1'b1;
    repeat (2 * bc) @(negedge clk);
    check_eq("R5 one byte after low hold", cap_n - base, 1);
    check_eq("R5 ferr set", cap_q[base % 256][9], 1);
    check_eq("R5 data", cap_q[base % 256][7:0], 8'h55);
    one_frame("R5 recovers", 8'hE7, 3, 0, 0, 0, 6);

    // R7 back-pressure holds
    @(negedge clk);
    m_ready = 1'b0;
    base = cap_n;
    send_frame(8'h11, 8, 0, 0, 0, 1'b1, bc);
    repeat (4) @(negedge clk);
    check_eq("R7 valid held", m_valid, 1);
    check_eq("R7 data held", m_data, 8'h11);
    repeat (60) @(negedge clk);
    check_eq("R7 still held", m_valid, 1);
    check_eq("R7 data still", m_data, 8'h11);
    m_ready = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R7 single accept", cap_n - base, 1);
    check_eq("R7 accepted data", cap_q[base % 256][7:0], 8'h11);

    // R8 overwrite of unaccepted byte
    m_ready = 1'b0;
    base = cap_n;
    send_frame(8'h22, 8, 0, 0, 0, 1'b1, bc);
    send_frame(8'h33, 8, 0, 0, 0, 1'b1, bc);
    repeat (4) @(negedge clk);
    check_eq("R8 newest shown", m_data, 8'h33);
    m_ready = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R8 one accept", cap_n - base, 1);
    check_eq("R8 accepted newest", cap_q[base % 256][7:0], 8'h33);

    // R8 accept and completion in the same cycle
    m_ready = 1'b0;
    base = cap_n;
    send_frame(8'h44, 8, 0, 0, 0, 1'b1, bc);
    repeat (4) @(negedge clk);
    fork
      send_frame(8'h66, 8, 0, 0, 0, 1'b1, bc);
      begin
        @(negedge clk);
        repeat (4 + bc / 2 + bc * 9 - 1) @(negedge clk);
        m_ready = 1'b1;
      end
    join
    repeat (4) @(negedge clk);
    check_eq("R8 same-cycle two bytes", cap_n - base, 2);
    check_eq("R8 same-cycle first", cap_q[base % 256][7:0], 8'h44);
    check_eq("R8 same-cycle second", cap_q[(base + 1) % 256][7:0], 8'h66);

    // random frames: R3 R4 R6
    for (int k = 0; k < 24; k++) begin
      one_frame("R3 R4 R6 random", 8'($urandom), int'($urandom % 4), 1'($urandom),
                1'($urandom), 1'($urandom), 4 + int'($urandom % 3));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule